// File: doc/BRIEF.md
# CAN Receive Message FIFO

This block keeps received CAN and CAN FD frames in a ring of fixed-size elements inside a 2 KB word-wide message RAM, and lets a host take them out oldest first. A frame arrives as one header beat, carrying the identifier and the 4-bit DLC, followed by a stream of data bytes. The block places each accepted frame into the element at its put index. It stores two header words and then only as many data bytes as the DLC asks for, clipped to the configured element data size. Bytes of the element beyond that count keep whatever an earlier frame left there.

The host sees the fill level, the get index and four flags. It reads any word of any element with one cycle of latency. It releases the oldest element by writing that element's index to the acknowledge port. Configuration inputs set the element base word, the number of elements, the data size code and the full policy. With the blocking policy, a frame that meets a full FIFO is dropped. With the overwrite policy, the frame replaces the oldest message.

Top module: `can_rx_fifo`

## Requirements
- R1: After a synchronous reset the fill level and get index are 0, the empty flag is 1, and the full, lost and overwrite flags are 0.
- R2: Element i starts at RAM word (base + i*stride) mod 512, where stride = 2 + W. W is 2, 3, 4, 5, 6, 8, 12 or 16 words for data size codes 0 to 7. Header word 0 holds the identifier in bits 28:0 with bits 31:29 zero. Header word 1 holds the DLC in bits 3:0 with all other bits zero. Data byte k goes to word 2 + k/4, bits 8*(k mod 4)+7 down to 8*(k mod 4).
- R3: A DLC of 0 to 8 stores that many bytes. DLC 9 to 15 stores 12, 16, 20, 24, 32, 48 and 64 bytes in turn. The count is clipped to 4*W. Bytes offered beyond the count are ignored.
- R4: Data bytes of the element past the stored count keep their previous contents and are not zeroed.
- R5: An accepted frame raises the fill level by one and advances the put index. Frames leave in arrival order.
- R6: An acknowledge is taken only when the FIFO is not empty and its index equals the get index. It advances the get index and lowers the fill level by one. Any other acknowledge changes nothing.
- R7: In blocking mode, a frame that arrives while the FIFO is full is discarded. Stored elements, fill level and get index stay unchanged, and the lost flag is set.
- R8: In overwrite mode, a frame that arrives while the FIFO is full is written into the element holding the oldest message. The get index advances, the fill level stays at full, and the overwrite flag is set.
- R9: The lost and overwrite flags stay set until the flag clear input is pulsed.
- R10: Element addresses that pass the last RAM word wrap to word 0.
- R11: The empty flag is 1 exactly when the fill level is 0. The full flag is 1 exactly when the fill level equals the configured element count, and the fill level never exceeds that count.
- R12: Read data and the read valid flag appear on the cycle after the read request. With no request, the valid flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | 9 | RAM word where element 0 starts |
| cfg_depth | input | 6 | Number of elements, 1 to 32 |
| cfg_dsize | input | 3 | Element data size code |
| cfg_overwrite | input | 1 | 1 = overwrite oldest when full, 0 = block |
| in_hdr_valid | input | 1 | Header beat of a new frame |
| in_id | input | 29 | Frame identifier |
| in_dlc | input | 4 | Frame DLC |
| in_byte_valid | input | 1 | Data byte beat |
| in_byte | input | 8 | Data byte |
| rd_en | input | 1 | Host word read request |
| rd_elem | input | 5 | Element index to read |
| rd_word | input | 5 | Word offset within the element |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data word |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_idx | input | 5 | Index of the consumed element |
| flag_clr | input | 1 | Clears the lost and overwrite flags |
| fill_level | output | 6 | Number of stored messages |
| get_idx | output | 5 | Index of the oldest message |
| flag_empty | output | 1 | FIFO empty |
| flag_full | output | 1 | FIFO full |
| flag_lost | output | 1 | A frame was dropped in blocking mode |
| flag_ovw | output | 1 | A frame overwrote the oldest message |

## Verification
The assertions take for granted that the frame source follows the beat rules:
- A header never arrives while the previous frame is still in flight.
- At least one idle cycle follows the last beat of a frame.
- Every accepted frame supplies at least as many bytes as its clipped DLC count.
- The configuration changes only right after reset.

The stimulus keeps within these rules because one task sends each frame. That task always offers at least the full stored count of bytes, leaves one idle cycle afterwards, and never raises an acknowledge while a frame is being written. Changes of configuration between phases are each preceded by a reset.

// File: rtl/can_rxf_pkg.sv
package can_rxf_pkg;

  localparam int HDR_WORDS = 2;

  // Stored byte count for a DLC code
  function automatic logic [6:0] dlc_to_bytes(input logic [3:0] dlc);
    case (dlc)
      4'd9:    return 7'd12;
      4'd10:   return 7'd16;
      4'd11:   return 7'd20;
      4'd12:   return 7'd24;
      4'd13:   return 7'd32;
      4'd14:   return 7'd48;
      4'd15:   return 7'd64;
      default: return {3'b000, dlc};
    endcase
  endfunction

  // Data words per element for a size code
  function automatic logic [4:0] dsize_words(input logic [2:0] code);
    case (code)
      3'd0:    return 5'd2;
      3'd1:    return 5'd3;
      3'd2:    return 5'd4;
      3'd3:    return 5'd5;
      3'd4:    return 5'd6;
      3'd5:    return 5'd8;
      3'd6:    return 5'd12;
      default: return 5'd16;
    endcase
  endfunction

  function automatic logic [4:0] elem_stride(input logic [2:0] code);
    return 5'(HDR_WORDS) + dsize_words(code);
  endfunction

endpackage

// File: rtl/rxf_msg_ram.sv
module rxf_msg_ram #(
  parameter int WORDS = 512,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [3:0]    wbe,
  input  logic [31:0]   wd,
  input  logic [AW-1:0] ra,
  output logic [31:0]   rd
);

  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    for (int b = 0; b < 4; b++) begin
      if (we && wbe[b]) mem[wa][8*b +: 8] <= wd[8*b +: 8];
    end
    rd <= mem[ra];
  end

endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl #(
  parameter int IDX_W = 5,
  parameter int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cfg_depth,
  input  logic             commit,
  input  logic             drop,
  input  logic             ack_valid,
  input  logic [IDX_W-1:0] ack_idx,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] fill_q,
  output logic [IDX_W-1:0] get_q,
  output logic [IDX_W-1:0] put_q,
  output logic             empty_q,
  output logic             full_q,
  output logic             lost_q,
  output logic             ovw_q
);

  logic             ack_ok;
  logic             ovw_ev;
  logic [CNT_W-1:0] fill_n;
  logic [IDX_W-1:0] last_idx;

  assign last_idx = IDX_W'(cfg_depth - CNT_W'(1));

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i,
                                            input logic [IDX_W-1:0] last);
    return (i == last) ? '0 : i + IDX_W'(1);
  endfunction

  always_comb begin
    ack_ok = ack_valid && (fill_q != '0) && (ack_idx == get_q);
    ovw_ev = commit && (fill_q == cfg_depth) && !ack_ok;
    fill_n = fill_q;
    if (commit && !ovw_ev) fill_n = fill_n + CNT_W'(1);
    if (ack_ok)            fill_n = fill_n - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q  <= '0;
      get_q   <= '0;
      put_q   <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
      lost_q  <= 1'b0;
      ovw_q   <= 1'b0;
    end else begin
      fill_q  <= fill_n;
      if (ack_ok || ovw_ev) get_q <= step(get_q, last_idx);
      if (commit)           put_q <= step(put_q, last_idx);
      empty_q <= (fill_n == '0);
      full_q  <= (fill_n == cfg_depth);
      if (drop)          lost_q <= 1'b1;
      else if (flag_clr) lost_q <= 1'b0;
      if (ovw_ev)        ovw_q  <= 1'b1;
      else if (flag_clr) ovw_q  <= 1'b0;
    end
  end

  p_fill_cap_r11: assert property (@(posedge clk) disable iff (rst)
    fill_q <= cfg_depth);

  p_ack_take_r6: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && fill_q != '0 && ack_idx == get_q && !commit)
      |=> fill_q == CNT_W'($past(fill_q) - CNT_W'(1)));

  p_ack_ignore_r6: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && ack_idx != get_q && !commit)
      |=> ($stable(fill_q) && $stable(get_q)));

  p_ovw_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (commit && fill_q == cfg_depth && !ack_valid)
      |=> (ovw_q && $stable(fill_q) && !$stable(get_q)));

  p_drop_lost_r7: assert property (@(posedge clk) disable iff (rst)
    (drop && !commit && !ack_valid) |=> (lost_q && $stable(fill_q) && $stable(get_q)));

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (lost_q && !flag_clr) |=> lost_q);

endmodule

// File: rtl/rxf_writer.sv
module rxf_writer
  import can_rxf_pkg::*;
#(
  parameter int AW    = 9,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    cfg_base,
  input  logic [2:0]       cfg_dsize,
  input  logic             cfg_overwrite,
  input  logic             full,
  input  logic [IDX_W-1:0] put_idx,
  input  logic             in_hdr_valid,
  input  logic [28:0]      in_id,
  input  logic [3:0]       in_dlc,
  input  logic             in_byte_valid,
  input  logic [7:0]       in_byte,
  output logic             we,
  output logic [AW-1:0]    wa,
  output logic [3:0]       wbe,
  output logic [31:0]      wd,
  output logic             commit,
  output logic             drop
);

  logic [4:0]    stride;
  logic [6:0]    cap_bytes;
  logic [6:0]    dlc_bytes;
  logic [6:0]    nb_in;
  logic [AW-1:0] ebase_c;
  logic          accept;

  logic [AW-1:0] ebase_q;
  logic [3:0]    dlc_q;
  logic [6:0]    nb_q;
  logic [6:0]    bcnt_q;
  logic          active_q;
  logic          hdr1_q;
  logic          bq_v;
  logic          bq_last;
  logic [AW-1:0] bq_addr;
  logic [3:0]    bq_be;
  logic [31:0]   bq_data;

  assign stride    = elem_stride(cfg_dsize);
  assign cap_bytes = {dsize_words(cfg_dsize), 2'b00};
  assign dlc_bytes = dlc_to_bytes(in_dlc);
  assign nb_in     = (dlc_bytes < cap_bytes) ? dlc_bytes : cap_bytes;
  assign ebase_c   = cfg_base + AW'(put_idx) * AW'(stride);
  assign drop      = in_hdr_valid && full && !cfg_overwrite;
  assign accept    = in_hdr_valid && !(full && !cfg_overwrite);
  assign commit    = (hdr1_q && nb_q == '0) || (bq_v && bq_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      ebase_q  <= '0;
      dlc_q    <= '0;
      nb_q     <= '0;
      bcnt_q   <= '0;
      active_q <= 1'b0;
      hdr1_q   <= 1'b0;
      bq_v     <= 1'b0;
      bq_last  <= 1'b0;
      bq_addr  <= '0;
      bq_be    <= '0;
      bq_data  <= '0;
    end else begin
      hdr1_q <= accept;
      if (accept) begin
        ebase_q  <= ebase_c;
        dlc_q    <= in_dlc;
        nb_q     <= nb_in;
        bcnt_q   <= '0;
        active_q <= (nb_in != '0);
      end else if (in_byte_valid && active_q) begin
        bcnt_q <= bcnt_q + 7'd1;
        if (bcnt_q == nb_q - 7'd1) active_q <= 1'b0;
      end
      bq_v    <= in_byte_valid && active_q && !accept;
      bq_last <= (bcnt_q == nb_q - 7'd1);
      bq_addr <= ebase_q + AW'(HDR_WORDS) + AW'(bcnt_q[6:2]);
      bq_be   <= 4'b0001 << bcnt_q[1:0];
      bq_data <= {4{in_byte}};
    end
  end

  // Single write port: header word 0, then header word 1, then data bytes
  always_comb begin
    we  = 1'b0;
    wa  = ebase_c;
    wbe = 4'hF;
    wd  = {3'b000, in_id};
    if (accept) begin
      we = 1'b1;
    end else if (hdr1_q) begin
      we = 1'b1;
      wa = ebase_q + AW'(1);
      wd = {28'd0, dlc_q};
    end else if (bq_v) begin
      we  = 1'b1;
      wa  = bq_addr;
      wbe = bq_be;
      wd  = bq_data;
    end
  end

  p_frame_gap_r5: assert property (@(posedge clk) disable iff (rst)
    in_hdr_valid |-> (!hdr1_q && !bq_v && !active_q));

  p_count_cap_r3: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (bcnt_q < nb_q));

  p_drop_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    drop |=> (!hdr1_q && !bq_v));

  p_dlc_word_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> (we && wa == $past(ebase_c) + AW'(1)));

endmodule

// File: rtl/can_rx_fifo.sv
module can_rx_fifo
  import can_rxf_pkg::*;
#(
  parameter int RAM_WORDS = 512,
  parameter int MAX_ELEM  = 32,
  localparam int AW    = $clog2(RAM_WORDS),
  localparam int IDX_W = $clog2(MAX_ELEM),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    cfg_base,
  input  logic [CNT_W-1:0] cfg_depth,
  input  logic [2:0]       cfg_dsize,
  input  logic             cfg_overwrite,
  input  logic             in_hdr_valid,
  input  logic [28:0]      in_id,
  input  logic [3:0]       in_dlc,
  input  logic             in_byte_valid,
  input  logic [7:0]       in_byte,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_elem,
  input  logic [4:0]       rd_word,
  output logic             rd_valid,
  output logic [31:0]      rd_data,
  input  logic             ack_valid,
  input  logic [IDX_W-1:0] ack_idx,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] fill_level,
  output logic [IDX_W-1:0] get_idx,
  output logic             flag_empty,
  output logic             flag_full,
  output logic             flag_lost,
  output logic             flag_ovw
);

  logic          we;
  logic [AW-1:0] wa;
  logic [3:0]    wbe;
  logic [31:0]   wd;
  logic [AW-1:0] ra;
  logic          commit;
  logic          drop;
  logic [IDX_W-1:0] put_idx;

  assign ra = cfg_base + AW'(rd_elem) * AW'(elem_stride(cfg_dsize)) + AW'(rd_word);

  rxf_writer #(.AW(AW), .IDX_W(IDX_W)) u_writer (
    .clk(clk), .rst(rst),
    .cfg_base(cfg_base), .cfg_dsize(cfg_dsize), .cfg_overwrite(cfg_overwrite),
    .full(flag_full), .put_idx(put_idx),
    .in_hdr_valid(in_hdr_valid), .in_id(in_id), .in_dlc(in_dlc),
    .in_byte_valid(in_byte_valid), .in_byte(in_byte),
    .we(we), .wa(wa), .wbe(wbe), .wd(wd),
    .commit(commit), .drop(drop)
  );

  rxf_ctrl #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .cfg_depth(cfg_depth),
    .commit(commit), .drop(drop),
    .ack_valid(ack_valid), .ack_idx(ack_idx), .flag_clr(flag_clr),
    .fill_q(fill_level), .get_q(get_idx), .put_q(put_idx),
    .empty_q(flag_empty), .full_q(flag_full),
    .lost_q(flag_lost), .ovw_q(flag_ovw)
  );

  rxf_msg_ram #(.WORDS(RAM_WORDS), .AW(AW)) u_ram (
    .clk(clk), .we(we), .wa(wa), .wbe(wbe), .wd(wd), .ra(ra), .rd(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= rd_en;
  end

  p_rd_lat_r12: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  p_rd_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

endmodule

// File: tb/test_can_rx_fifo.sv
module test_can_rx_fifo;

  localparam int CLK_PERIOD = 10;
  localparam int RAMW = 512;

  logic        clk = 1'b0;
  logic        rst;
  logic [8:0]  cfg_base;
  logic [5:0]  cfg_depth;
  logic [2:0]  cfg_dsize;
  logic        cfg_overwrite;
  logic        in_hdr_valid, in_byte_valid;
  logic [28:0] in_id;
  logic [3:0]  in_dlc;
  logic [7:0]  in_byte;
  logic        rd_en, rd_valid;
  logic [4:0]  rd_elem, rd_word;
  logic [31:0] rd_data;
  logic        ack_valid, flag_clr;
  logic [4:0]  ack_idx;
  logic [5:0]  fill_level;
  logic [4:0]  get_idx;
  logic        flag_empty, flag_full, flag_lost, flag_ovw;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_rx_fifo i_can_rx_fifo (
    .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_depth(cfg_depth),
    .cfg_dsize(cfg_dsize), .cfg_overwrite(cfg_overwrite),
    .in_hdr_valid(in_hdr_valid), .in_id(in_id), .in_dlc(in_dlc),
    .in_byte_valid(in_byte_valid), .in_byte(in_byte),
    .rd_en(rd_en), .rd_elem(rd_elem), .rd_word(rd_word),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .ack_valid(ack_valid), .ack_idx(ack_idx), .flag_clr(flag_clr),
    .fill_level(fill_level), .get_idx(get_idx),
    .flag_empty(flag_empty), .flag_full(flag_full),
    .flag_lost(flag_lost), .flag_ovw(flag_ovw)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Bench model of the RAM at byte level, with a known mask
  logic [7:0] shb [RAMW*4];
  bit         shk [RAMW*4];
  int m_fill, m_get, m_put;
  bit m_lost, m_ovw;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int dlcb(input int d);
    case (d)
      9: return 12; 10: return 16; 11: return 20; 12: return 24;
      13: return 32; 14: return 48; 15: return 64;
      default: return d;
    endcase
  endfunction

  function automatic int dwords(input int c);
    case (c)
      0: return 2; 1: return 3; 2: return 4; 3: return 5;
      4: return 6; 5: return 8; 6: return 12; default: return 16;
    endcase
  endfunction

  function automatic int strd();
    return 2 + dwords(int'(cfg_dsize));
  endfunction

  function automatic logic [7:0] pat(input int id, input int k);
    return 8'((id * 7 + k * 13 + 5) & 255);
  endfunction

  task automatic sh_put(input int waddr, input int lane, input logic [7:0] v);
    int i;
    i = (waddr % RAMW) * 4 + lane;
    shb[i] = v;
    shk[i] = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_fill = 0; m_get = 0; m_put = 0; m_lost = 0; m_ovw = 0;
    @(negedge clk);
  endtask

  task automatic check_state(input string req);
    chk(fill_level == 6'(m_fill), {req, " fill"}, fill_level, m_fill);
    chk(get_idx == 5'(m_get), {req, " get"}, get_idx, m_get);
    chk(flag_empty == (m_fill == 0), {req, " R11 empty"}, flag_empty, m_fill == 0);
    chk(flag_full == (m_fill == int'(cfg_depth)), {req, " R11 full"}, flag_full,
        m_fill == int'(cfg_depth));
    chk(flag_lost == m_lost, {req, " R9 lost"}, flag_lost, m_lost);
    chk(flag_ovw == m_ovw, {req, " R9 ovw"}, flag_ovw, m_ovw);
  endtask

  task automatic send(input int id, input int dlc, input int nsend);
    bit acc;
    int base, n;
    acc = !(m_fill == int'(cfg_depth) && !cfg_overwrite);
    @(negedge clk);
    in_hdr_valid = 1'b1; in_id = 29'(id); in_dlc = 4'(dlc);
    @(negedge clk);
    in_hdr_valid = 1'b0;
    for (int k = 0; k < nsend; k++) begin
      in_byte_valid = 1'b1; in_byte = pat(id, k);
      @(negedge clk);
    end
    in_byte_valid = 1'b0;
    @(negedge clk);
    if (!acc) begin
      m_lost = 1'b1;
    end else begin
      base = int'(cfg_base) + m_put * strd();
      for (int b = 0; b < 4; b++) sh_put(base, b, 8'((id & 32'h1FFF_FFFF) >> (8 * b)));
      for (int b = 0; b < 4; b++) sh_put(base + 1, b, (b == 0) ? 8'(dlc) : 8'h00);
      n = dlcb(dlc);
      if (n > 4 * dwords(int'(cfg_dsize))) n = 4 * dwords(int'(cfg_dsize));
      for (int k = 0; k < n; k++) sh_put(base + 2 + k / 4, k % 4, pat(id, k));
      if (m_fill == int'(cfg_depth)) begin
        m_get = (m_get + 1) % int'(cfg_depth);
        m_ovw = 1'b1;
      end else begin
        m_fill++;
      end
      m_put = (m_put + 1) % int'(cfg_depth);
    end
  endtask

  task automatic ack(input int idx);
    @(negedge clk);
    ack_valid = 1'b1; ack_idx = 5'(idx);
    @(negedge clk);
    ack_valid = 1'b0;
    if (m_fill > 0 && idx == m_get) begin
      m_fill--;
      m_get = (m_get + 1) % int'(cfg_depth);
    end
  endtask

  task automatic clear_flags();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    m_lost = 0; m_ovw = 0;
  endtask

  task automatic check_elem(input int idx, input string req);
    int base, a;
    bit ok;
    logic [31:0] exp;
    base = int'(cfg_base) + idx * strd();
    for (int w = 0; w < strd(); w++) begin
      @(negedge clk);
      rd_en = 1'b1; rd_elem = 5'(idx); rd_word = 5'(w);
      @(negedge clk);
      rd_en = 1'b0;
      chk(rd_valid === 1'b1, "R12 rd_valid", rd_valid, 1);
      a = ((base + w) % RAMW) * 4;
      ok = 1'b1;
      exp = rd_data;
      for (int b = 0; b < 4; b++) begin
        if (shk[a + b]) begin
          exp[8*b +: 8] = shb[a + b];
          if (rd_data[8*b +: 8] !== shb[a + b]) ok = 1'b0;
        end
      end
      chk(ok, req, rd_data, exp);
    end
    @(negedge clk);
    chk(rd_valid === 1'b0, "R12 idle", rd_valid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < RAMW * 4; i++) shk[i] = 1'b0;
    rst = 1'b1; in_hdr_valid = 0; in_byte_valid = 0; in_id = '0; in_dlc = '0;
    in_byte = '0; rd_en = 0; rd_elem = '0; rd_word = '0; ack_valid = 0;
    ack_idx = '0; flag_clr = 0;
    cfg_base = 9'd500; cfg_depth = 6'd3; cfg_dsize = 3'd1; cfg_overwrite = 1'b0;
    do_reset();
    check_state("R1");

    // Three full elements, base near the RAM end (element 2 wraps): R10
    send(32'h101, 9, 12);
    send(32'h1ABCDEF, 9, 12);
    send(32'h2, 9, 12);
    check_state("R5");
    check_elem(0, "R2 R5");
    check_elem(1, "R2 R5");
    check_elem(2, "R2 R10");

    // Blocking drop: R7
    send(32'h3, 8, 8);
    check_state("R7");
    check_elem(0, "R7 contents");

    // Wrong index acknowledge is ignored: R6
    ack(1);
    check_state("R6 ignore");
    ack(0);
    check_state("R6 take");

    // Short frame into element 0 with extra bytes offered: R3 R4
    send(32'h44, 2, 6);
    check_elem(0, "R3 R4 stale");
    check_state("R5 refill");

    clear_flags();
    check_state("R9 clear");

    // Overwrite of oldest with clipped DLC: R8 R3
    cfg_overwrite = 1'b1;
    send(32'h55, 15, 16);
    check_state("R8");
    check_elem(1, "R8 R3 clip");
    ack(2); ack(0); ack(1);
    check_state("R9 R11 drained");
    clear_flags();
    check_state("R9 clear2");

    // DLC sweep with the largest element: R3 R4
    cfg_overwrite = 1'b0; cfg_base = 9'd100; cfg_depth = 6'd2; cfg_dsize = 3'd7;
    do_reset();
    check_state("R1 again");
    for (int d = 0; d < 16; d++) begin
      send(32'h300 + d, d, 64);
      check_elem(m_get, "R3 R4 sweep");
      ack(m_get);
    end
    check_state("R6 sweep");

    // Size code sweep across the wrap point: R2 R10
    for (int c = 0; c < 8; c++) begin
      cfg_base = 9'd508; cfg_dsize = 3'(c); cfg_depth = 6'd2;
      do_reset();
      send(32'h600 + c, 15, 64);
      send(32'h700 + c, 15, 64);
      check_state("R11 size full");
      check_elem(0, "R2 R10 size");
      check_elem(1, "R2 R10 size");
      ack(0); ack(1);
      check_state("R6 size");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule